// File: doc/BRIEF.md
# Colour Palette CPU Access Port

This block gives the host processor byte-wide access to a 512-byte colour palette store. The store holds 15-bit colours as pairs of bytes: the even byte carries the low eight colour bits and the odd byte carries the upper seven. The incoming host address is cut to its low 9 bits. Bit 7 of any odd byte is forced to zero, both on the way into the store and on the way back out.

A static parameter can enable a redirect mode, which models contention with the display renderer. In this mode, an access made while the beam is inside the visible window does not use the host address. It goes to a palette pointer supplied by the renderer, and its data is limited to 7 bits. The visible window spans scanlines below 225, or below 240 with overscan, and dots from 128 up to but not including 1096. Asserting the display-off input suppresses redirection. With the mode disabled, which is the default, every access uses the host address whatever the beam position.

Reads are registered: the byte appears on the read data output one clock after the read strobe, together with a valid flag. A write and a read may be issued in the same cycle.

Top module: `pal_port`

## Requirements
- R1: Only bits 8:0 of `addr_i` select a byte. Addresses that differ only in bits 15:9 refer to the same byte.
- R2: A direct write to an odd address stores the data with bit 7 cleared. A write to an even address stores all 8 bits.
- R3: A read from an odd host address returns bit 7 as zero.
- R4: A byte written to an even address, with no redirection in effect, reads back unchanged.
- R5: `rvalid_o` is high in exactly the cycle after a cycle in which `rd_en_i` was high. `rdata_o` carries the byte in that same cycle.
- R6: While `rst_ni` is low, `rvalid_o` and `rdata_o` are zero.
- R7: With `REDIRECT_EN`=1, an access is redirected only when all of the following hold:
  - `disp_off_i` is low;
  - `scan_i` is below 225 when `overscan_i`=0, or below 240 when `overscan_i`=1;
  - `dot_i` is at least 128 and below 1096.
- R8: A redirected write stores `wdata_i & 8'h7F` at `rend_addr_i`. It leaves the byte at the host address untouched.
- R9: A redirected read returns the byte at `rend_addr_i` with bit 7 cleared.
- R10: With `REDIRECT_EN`=0, every access uses the host address, whatever the beam counters and display state.
- R11: While `disp_off_i` is high, no access is redirected.
- R12: When a read and a write occur in the same cycle, the read returns the contents from before the write. The write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 16 | Host byte address (low 9 bits used) |
| wdata_i | input | 8 | Write data |
| scan_i | input | 9 | Current scanline |
| dot_i | input | 11 | Current dot within the line |
| overscan_i | input | 1 | Selects the 240-line visible height |
| disp_off_i | input | 1 | Display disabled; blocks redirection |
| rend_addr_i | input | 9 | Renderer palette pointer |
| rdata_o | output | 8 | Read data, one cycle after the strobe |
| rvalid_o | output | 1 | Read data valid |

## Verification
Several checks run on every clock cycle:
- the read latency and the valid flag;
- the cleared bit 7 on odd reads and on redirected reads;
- the cleared bit 7 on every odd byte entering the store;
- the guarantees that a display-off write, or a write left of dot 128, lands on the host address.

Other behaviour needs the bench's scenarios:
- address aliasing;
- exact window edges at dot 127/128 and 1095/1096, and at lines 224/225 and 239/240;
- a redirected write leaving the host byte untouched;
- read-before-write ordering.

To show these, the bench runs two copies of the block, one with redirect mode and one without, against a reference model of the whole store.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int unsigned HOST_AW   = 16;
  localparam int unsigned PAL_AW    = 9;
  localparam int unsigned DATA_W    = 8;
  localparam int unsigned SCAN_W    = 9;
  localparam int unsigned DOT_W     = 11;
  localparam int unsigned LINES_STD = 225;
  localparam int unsigned LINES_OS  = 240;
  localparam int unsigned DOT_FIRST = 128;
  localparam int unsigned DOT_LIMIT = 1096;
endpackage

// File: rtl/pal_window.sv
module pal_window #(
  parameter bit          REDIRECT_EN = 1'b0,
  parameter int unsigned SCAN_W      = pal_pkg::SCAN_W,
  parameter int unsigned DOT_W       = pal_pkg::DOT_W,
  parameter int unsigned LINES_STD   = pal_pkg::LINES_STD,
  parameter int unsigned LINES_OS    = pal_pkg::LINES_OS,
  parameter int unsigned DOT_FIRST   = pal_pkg::DOT_FIRST,
  parameter int unsigned DOT_LIMIT   = pal_pkg::DOT_LIMIT
) (
  input  logic [SCAN_W-1:0] scan_i,
  input  logic [DOT_W-1:0]  dot_i,
  input  logic              overscan_i,
  input  logic              disp_off_i,
  output logic              redir_o
);
  localparam logic [SCAN_W-1:0] LIM_STD = SCAN_W'(LINES_STD);
  localparam logic [SCAN_W-1:0] LIM_OS  = SCAN_W'(LINES_OS);
  localparam logic [DOT_W-1:0]  D_LO    = DOT_W'(DOT_FIRST);
  localparam logic [DOT_W-1:0]  D_HI    = DOT_W'(DOT_LIMIT);

  generate
    if (REDIRECT_EN) begin : g_win
      logic [SCAN_W-1:0] line_lim;
      logic in_lines, in_dots;
      assign line_lim = overscan_i ? LIM_OS : LIM_STD;
      assign in_lines = scan_i < line_lim;
      assign in_dots  = (dot_i >= D_LO) && (dot_i < D_HI);
      assign redir_o  = !disp_off_i && in_lines && in_dots;
    end else begin : g_nowin
      logic unused_win;
      assign unused_win = ^{scan_i, dot_i, overscan_i, disp_off_i};
      assign redir_o    = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/pal_route.sv
module pal_route #(
  parameter int unsigned PAL_AW = pal_pkg::PAL_AW,
  parameter int unsigned DATA_W = pal_pkg::DATA_W
) (
  input  logic [PAL_AW-1:0] host_addr_i,
  input  logic [PAL_AW-1:0] rend_addr_i,
  input  logic              redir_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [PAL_AW-1:0] eff_addr_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              clr_msb_o
);
  // redirected data and odd (high) bytes both lose the top bit
  assign clr_msb_o  = redir_i | host_addr_i[0];
  assign eff_addr_o = redir_i ? rend_addr_i : host_addr_i;
  assign wdata_o    = clr_msb_o ? {1'b0, wdata_i[DATA_W-2:0]} : wdata_i;
endmodule

// File: rtl/pal_store.sv
module pal_store #(
  parameter int unsigned PAL_AW = pal_pkg::PAL_AW,
  parameter int unsigned DATA_W = pal_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [PAL_AW-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              host_odd_i,
  input  logic              clr_msb_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o
);
  localparam int unsigned DEPTH = 1 << PAL_AW;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DATA_W-1:0] rd_word;

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rd_word = clr_msb_i ? {1'b0, mem_q[addr_i][DATA_W-2:0]} : mem_q[addr_i];

  // read-first: captures the array before the same-cycle write lands
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= re_i;
      if (re_i) rdata_o <= rd_word;
    end
  end

  // R2: an odd host byte never enters the array with bit 7 set
  a_r2_odd_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && host_odd_i) |-> !wdata_i[DATA_W-1]);
endmodule

// File: rtl/pal_port.sv
module pal_port #(
  parameter bit          REDIRECT_EN = 1'b0,
  parameter int unsigned HOST_AW     = pal_pkg::HOST_AW,
  parameter int unsigned PAL_AW      = pal_pkg::PAL_AW,
  parameter int unsigned DATA_W      = pal_pkg::DATA_W,
  parameter int unsigned SCAN_W      = pal_pkg::SCAN_W,
  parameter int unsigned DOT_W       = pal_pkg::DOT_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [HOST_AW-1:0] addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [SCAN_W-1:0]  scan_i,
  input  logic [DOT_W-1:0]   dot_i,
  input  logic               overscan_i,
  input  logic               disp_off_i,
  input  logic [PAL_AW-1:0]  rend_addr_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               rvalid_o
);
  localparam logic [DOT_W-1:0] D_LO = DOT_W'(pal_pkg::DOT_FIRST);

  logic [PAL_AW-1:0] host_addr;
  logic [PAL_AW-1:0] eff_addr;
  logic [DATA_W-1:0] st_wdata;
  logic              redir, clr_msb;
  logic              unused_addr_hi;

  assign host_addr      = addr_i[PAL_AW-1:0];
  assign unused_addr_hi = ^addr_i[HOST_AW-1:PAL_AW];

  pal_window #(.REDIRECT_EN(REDIRECT_EN), .SCAN_W(SCAN_W), .DOT_W(DOT_W)) u_win (
    .scan_i     (scan_i),
    .dot_i      (dot_i),
    .overscan_i (overscan_i),
    .disp_off_i (disp_off_i),
    .redir_o    (redir)
  );

  pal_route #(.PAL_AW(PAL_AW), .DATA_W(DATA_W)) u_route (
    .host_addr_i (host_addr),
    .rend_addr_i (rend_addr_i),
    .redir_i     (redir),
    .wdata_i     (wdata_i),
    .eff_addr_o  (eff_addr),
    .wdata_o     (st_wdata),
    .clr_msb_o   (clr_msb)
  );

  pal_store #(.PAL_AW(PAL_AW), .DATA_W(DATA_W)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (wr_en_i),
    .re_i       (rd_en_i),
    .addr_i     (eff_addr),
    .wdata_i    (st_wdata),
    .host_odd_i (host_addr[0] && !redir),
    .clr_msb_i  (clr_msb),
    .rdata_o    (rdata_o),
    .rvalid_o   (rvalid_o)
  );

  // R5: valid follows the read strobe by exactly one cycle
  a_r5_valid_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rvalid_o);
  a_r5_valid_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rvalid_o);
  // R3: odd host read never shows bit 7
  a_r3_odd_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i[0]) |=> !rdata_o[DATA_W-1]);
  // R9: redirected read is 7-bit
  a_r9_redir_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && redir) |=> !rdata_o[DATA_W-1]);
  // R11: display off keeps the host address
  a_r11_disp_off_direct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && disp_off_i) |-> (eff_addr == host_addr));
  // R7: left of the window the host address is used
  a_r7_left_direct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && (dot_i < D_LO)) |-> (eff_addr == host_addr));
endmodule

// File: tb/pal_port_tb_top.sv
`timescale 1ns/1ps
module pal_port_tb_top;
  typedef struct {
    logic [7:0] exp;
    string      tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [8:0]  scan = '0;
  logic [10:0] dot = '0;
  logic        os = 1'b0, doff = 1'b0;
  logic [8:0]  rend = 9'h040;
  logic [7:0]  rdata0, rdata1;
  logic        rvalid0, rvalid1;

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] m0 [512];
  logic [7:0] m1 [512];
  item_t q0[$];
  item_t q1[$];

  always #2 clk = ~clk;

  pal_port #(.REDIRECT_EN(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .scan_i(scan), .dot_i(dot), .overscan_i(os), .disp_off_i(doff),
    .rend_addr_i(rend), .rdata_o(rdata0), .rvalid_o(rvalid0));

  pal_port #(.REDIRECT_EN(1'b1)) dut_r_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .scan_i(scan), .dot_i(dot), .overscan_i(os), .disp_off_i(doff),
    .rend_addr_i(rend), .rdata_o(rdata1), .rvalid_o(rvalid1));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // driver: applies one access and pushes expected read bytes for both copies
  task automatic step(input bit wr, input bit rd, input logic [15:0] a, input logic [7:0] d,
                      input int sc, input int dt, input bit o, input bit off, input string tag);
    @(negedge clk);
    wr_en = wr; rd_en = rd; addr = a; wdata = d;
    scan = 9'(sc); dot = 11'(dt); os = o; doff = off;
    for (int k = 0; k < 2; k++) begin
      bit rdir;
      bit clr;
      logic [8:0] ea;
      logic [7:0] cur;
      rdir = (k == 1) && !off && (sc < (o ? 240 : 225)) && (dt >= 128) && (dt < 1096);
      ea   = rdir ? rend : a[8:0];
      clr  = rdir || a[0];
      cur  = (k == 0) ? m0[ea] : m1[ea];
      if (rd) begin
        item_t it;
        it.exp = clr ? (cur & 8'h7f) : cur;
        it.tag = $sformatf("%s dut%0d", tag, k);
        if (k == 0) q0.push_back(it); else q1.push_back(it);
      end
      if (wr) begin
        if (k == 0) m0[ea] = clr ? (d & 8'h7f) : d;
        else        m1[ea] = clr ? (d & 8'h7f) : d;
      end
    end
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  // monitor
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      if (rvalid0) begin
        if (q0.size() == 0) check("R5 unexpected valid dut0", rdata0, 8'hxx);
        else begin item_t it; it = q0.pop_front(); check(it.tag, rdata0, it.exp); end
      end
      if (rvalid1) begin
        if (q1.size() == 0) check("R5 unexpected valid dut1", rdata1, 8'hxx);
        else begin item_t it; it = q1.pop_front(); check(it.tag, rdata1, it.exp); end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R6 reset rvalid dut0", {7'd0, rvalid0}, 8'h00);
    check("R6 reset rdata dut0", rdata0, 8'h00);
    check("R6 reset rvalid dut1", {7'd0, rvalid1}, 8'h00);
    check("R6 reset rdata dut1", rdata1, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    // fill both copies outside the window
    for (int i = 0; i < 512; i++) step(1, 0, 16'(i), 8'(i * 37 + 11), 0, 0, 0, 0, "init");
    idle();

    // R4 / R2 / R3: direct round trips outside the window
    step(1, 0, 16'h0010, 8'hA5, 250, 10, 0, 0, "R4 even write");
    step(0, 1, 16'h0010, 8'h00, 250, 10, 0, 0, "R4 even read");
    step(1, 0, 16'h0011, 8'hFF, 250, 10, 0, 0, "R2 odd write");
    step(0, 1, 16'h0011, 8'h00, 250, 10, 0, 0, "R2 R3 odd read");
    // R1: aliasing via high address bits
    step(1, 0, 16'hFE10, 8'h3C, 250, 10, 0, 0, "R1 alias write");
    step(0, 1, 16'h0010, 8'h00, 250, 10, 0, 0, "R1 alias read");
    step(0, 1, 16'h8011, 8'h00, 250, 10, 0, 0, "R1 alias odd read");
    // R12: read-first in same cycle
    step(1, 1, 16'h0020, 8'h99, 250, 10, 0, 0, "R12 same-cycle read");
    step(0, 1, 16'h0020, 8'h00, 250, 10, 0, 0, "R12 after write");
    idle();
    // R8 / R10: write inside the window
    step(1, 0, 16'h0006, 8'hC3, 10, 500, 0, 0, "R8 R10 window write");
    step(0, 1, 16'h0006, 8'h00, 250, 10, 0, 0, "R8 host byte untouched");
    step(0, 1, 16'h0040, 8'h00, 250, 10, 0, 0, "R8 renderer byte");
    // R9: read inside the window
    step(0, 1, 16'h0002, 8'h00, 10, 500, 0, 0, "R9 R10 window read");
    step(1, 0, 16'h0040, 8'hF0, 250, 10, 0, 0, "R9 preset");
    step(0, 1, 16'h0004, 8'h00, 100, 300, 0, 0, "R9 masked read");
    idle();
    // R7: edges of the window
    step(0, 1, 16'h0008, 8'h00, 10, 127, 0, 0, "R7 dot 127");
    step(0, 1, 16'h0008, 8'h00, 10, 128, 0, 0, "R7 dot 128");
    step(0, 1, 16'h0008, 8'h00, 10, 1095, 0, 0, "R7 dot 1095");
    step(0, 1, 16'h0008, 8'h00, 10, 1096, 0, 0, "R7 dot 1096");
    step(0, 1, 16'h0008, 8'h00, 224, 500, 0, 0, "R7 line 224");
    step(0, 1, 16'h0008, 8'h00, 225, 500, 0, 0, "R7 line 225");
    step(0, 1, 16'h0008, 8'h00, 239, 500, 1, 0, "R7 overscan line 239");
    step(0, 1, 16'h0008, 8'h00, 240, 500, 1, 0, "R7 overscan line 240");
    step(1, 0, 16'h000A, 8'h8E, 10, 127, 0, 0, "R7 write at dot 127");
    step(0, 1, 16'h000A, 8'h00, 250, 10, 0, 0, "R7 read back dot 127");
    idle();
    // R11: display off inside the window
    step(1, 0, 16'h000C, 8'hB7, 10, 500, 0, 1, "R11 write display off");
    step(0, 1, 16'h000C, 8'h00, 10, 500, 0, 1, "R11 read display off");
    step(0, 1, 16'h0040, 8'h00, 250, 10, 0, 0, "R11 renderer byte unchanged");
    idle();
    repeat (4) @(posedge clk);
    #1;
    check("R5 queue drained dut0", 8'(q0.size()), 8'h00);
    check("R5 queue drained dut1", 8'(q1.size()), 8'h00);
    check("R5 idle valid", {6'd0, rvalid1, rvalid0}, 8'h00);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule